// File: doc/BRIEF.md
# SDA Output Conditioning Stage

This block sits between the serial data bit produced by a shift engine and an open-drain SDA pad. It can hold every change of the data bit back by a programmable number of count-source clock ticks. It can replace the shifted bit with a software-held acknowledge level. It can release the pad unconditionally. While the serial interface is disabled, it drives a programmable idle level.

A small three-state controller picks the output source. The states are `ST_OFF` (interface disabled), `ST_RUN` (normal data path) and `ST_FLOAT` (forced release). The controller registers its choice on each clock edge with a fixed priority:

- Force-release high selects `ST_FLOAT` from any state.
- Otherwise, a low interface-enable selects `ST_OFF`.
- Otherwise, the next state is `ST_RUN`.

The delay is an eight-stage shift line that advances only on count-source tick pulses. The select picks a tap from it. Select 0 bypasses the line.

Top module: `sda_out_cond`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the controller is in `ST_OFF`, every delay stage holds 1, and with `idle_level` high the pad is released (`pad_o`=1, `pad_oe`=0).
- R2: In the cycle after a clock edge that sampled `if_enable`=0 and `hiz_force`=0, `pad_o` equals `idle_level` and `pad_oe` equals its inverse.
- R3: Open-drain encoding: `pad_oe`=1 means the pad is pulled low and `pad_o` is then 0; a high level is shown as `pad_o`=1 with `pad_oe`=0.
- R4: In the cycle after a clock edge that sampled `hiz_force`=1, the pad is released (`pad_oe`=0, `pad_o`=1), whatever the data, acknowledge, enable and idle inputs are.
- R5: In `ST_RUN` with `dly_sel`=0, the pad level follows the selected data bit in the same cycle, with no register in between.
- R6: In `ST_RUN` with `dly_sel`=s (1 to 7), a new data level reaches the pad after the (s+1)-th `cs_tick` pulse following the change. Clock cycles without `cs_tick` do not move the shift line.
- R7: When `ss_out_en`=0 and `ack_out_en`=1, `ack_val` replaces `sda_raw` at the input of the delay path, and it is delayed exactly like shifted data.
- R8: When `ss_out_en`=1 or `ack_out_en`=0, `ack_val` has no effect and the pad carries `sda_raw`.
- R9: While the controller is in `ST_OFF`, every delay stage is loaded with `idle_level`. After enable, the pad shows that idle level until new data has passed through the selected delay.
- R10: State transitions take effect one clock after the inputs change: `ST_RUN`→`ST_FLOAT` on `hiz_force`, `ST_FLOAT`→`ST_OFF` when `hiz_force` drops with `if_enable` low, and `ST_OFF`→`ST_RUN` on `if_enable`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_tick | input | 1 | One-cycle count-source tick that advances the delay line |
| sda_raw | input | 1 | Data bit from the shift engine |
| dly_sel | input | 3 | 0 = no delay; s = 1..7 gives s+1 ticks of delay |
| ss_out_en | input | 1 | Start/stop generation active; blocks acknowledge substitution when high |
| ack_out_en | input | 1 | Enable acknowledge substitution |
| ack_val | input | 1 | Acknowledge level driven when substitution is active |
| hiz_force | input | 1 | Force the pad released |
| if_enable | input | 1 | Serial interface enabled |
| idle_level | input | 1 | Level driven while the interface is disabled |
| pad_o | output | 1 | Pad level (1 = released/high) |
| pad_oe | output | 1 | Pull-down enable (1 = drive low) |

## Verification
A controller stuck in the wrong state shows on the ports one clock after the enable or force inputs change. A stuck `ST_RUN` drives data where the idle level or a release is expected, and a stuck `ST_FLOAT` keeps `pad_oe` low. A shift line that advances without ticks, or a wrong tap, moves the data edge at the pad by at least one tick against the s+1 count. A missing flush shows stale data in the first cycles after enable instead of the idle level. A substitution mux with wrong gating puts `ack_val` on the pad where `sda_raw` belongs in the same cycle, because select 0 is combinational.

// File: rtl/sda_out_cond_pkg.sv
package sda_out_cond_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLOAT = 2'd2
    } cond_state_e;
endpackage

// File: rtl/sda_src_mux.sv
module sda_src_mux (
    input  logic sda_raw,
    input  logic ss_out_en,
    input  logic ack_out_en,
    input  logic ack_val,
    output logic src_bit
);
    // Acknowledge substitution only when start/stop generation is off.
    logic ack_sel;
    assign ack_sel = ack_out_en & ~ss_out_en;
    assign src_bit = ack_sel ? ack_val : sda_raw;
endmodule

// File: rtl/sda_delay_line.sv
module sda_delay_line #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             flush_val,
    input  logic             tick,
    input  logic             din,
    input  logic [SEL_W-1:0] sel,
    output logic             tap
);
    localparam int DEPTH = 1 << SEL_W;

    logic [DEPTH-1:0] stage;

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      stage[g] <= 1'b1;
                else if (flush)  stage[g] <= flush_val;
                else if (tick)   stage[g] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      stage[g] <= 1'b1;
                else if (flush)  stage[g] <= flush_val;
                else if (tick)   stage[g] <= stage[g-1];
            end
        end
    end

    // Select 0 bypasses the line; select s taps the stage loaded s+1 ticks ago.
    assign tap = (sel == '0) ? din : stage[sel];
endmodule

// File: rtl/sda_ctrl_fsm.sv
module sda_ctrl_fsm
    import sda_out_cond_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hiz_force,
    input  logic        if_enable,
    output cond_state_e state
);
    cond_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: begin
                if (hiz_force)      state_nx = ST_FLOAT;
                else if (if_enable) state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (hiz_force)       state_nx = ST_FLOAT;
                else if (!if_enable) state_nx = ST_OFF;
            end
            ST_FLOAT: begin
                if (!hiz_force) state_nx = if_enable ? ST_RUN : ST_OFF;
            end
            default: state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end
endmodule

// File: rtl/sda_out_cond.sv
module sda_out_cond
    import sda_out_cond_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_tick,
    input  logic             sda_raw,
    input  logic [SEL_W-1:0] dly_sel,
    input  logic             ss_out_en,
    input  logic             ack_out_en,
    input  logic             ack_val,
    input  logic             hiz_force,
    input  logic             if_enable,
    input  logic             idle_level,
    output logic             pad_o,
    output logic             pad_oe
);
    cond_state_e state;
    logic        src_bit;
    logic        tap_bit;
    logic        level;

    sda_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hiz_force (hiz_force),
        .if_enable (if_enable),
        .state     (state)
    );

    sda_src_mux u_mux (
        .sda_raw    (sda_raw),
        .ss_out_en  (ss_out_en),
        .ack_out_en (ack_out_en),
        .ack_val    (ack_val),
        .src_bit    (src_bit)
    );

    sda_delay_line #(.SEL_W(SEL_W)) u_dly (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (state == ST_OFF),
        .flush_val (idle_level),
        .tick      (cs_tick),
        .din       (src_bit),
        .sel       (dly_sel),
        .tap       (tap_bit)
    );

    // Output decode from the current state.
    always_comb begin
        level = 1'b1;
        unique case (state)
            ST_OFF:   level = idle_level;
            ST_RUN:   level = tap_bit;
            ST_FLOAT: level = 1'b1;
            default:  level = 1'b1;
        endcase
    end

    assign pad_o  = level;
    assign pad_oe = ~level;
endmodule

// File: rtl/sda_out_cond_chk.sv
module sda_out_cond_chk #(
    parameter int SEL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_tick,
    input logic             sda_raw,
    input logic [SEL_W-1:0] dly_sel,
    input logic             ss_out_en,
    input logic             ack_out_en,
    input logic             ack_val,
    input logic             hiz_force,
    input logic             if_enable,
    input logic             idle_level,
    input logic             pad_o,
    input logic             pad_oe
);
    logic pv1, pv2;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pv1 <= 1'b0;
            pv2 <= 1'b0;
        end else begin
            pv1 <= 1'b1;
            pv2 <= pv1;
        end
    end

    assert_od_encoding_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe |-> !pad_o);

    assert_force_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pv1 && $past(hiz_force)) |-> (!pad_oe && pad_o));

    assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pv1 && !$past(if_enable) && !$past(hiz_force))
        |-> (pad_o == idle_level && pad_oe == !idle_level));

    assert_zero_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pv1 && $past(if_enable) && !$past(hiz_force) && dly_sel == '0 && ss_out_en)
        |-> (pad_o == sda_raw));

    assert_ack_subst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pv1 && $past(if_enable) && !$past(hiz_force) && dly_sel == '0
         && !ss_out_en && ack_out_en)
        |-> (pad_o == ack_val));

    assert_no_tick_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pv2 && $past(if_enable, 2) && $past(if_enable) && !$past(hiz_force, 2)
         && !$past(hiz_force) && dly_sel != '0 && $stable(dly_sel) && !$past(cs_tick))
        |-> $stable(pad_o));
endmodule

bind sda_out_cond sda_out_cond_chk #(.SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_tick    (cs_tick),
    .sda_raw    (sda_raw),
    .dly_sel    (dly_sel),
    .ss_out_en  (ss_out_en),
    .ack_out_en (ack_out_en),
    .ack_val    (ack_val),
    .hiz_force  (hiz_force),
    .if_enable  (if_enable),
    .idle_level (idle_level),
    .pad_o      (pad_o),
    .pad_oe     (pad_oe)
);

// File: tb/sda_out_cond_test.sv
`timescale 1ns/1ps
module sda_out_cond_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_tick = 1'b0;
    logic       sda_raw = 1'b1;
    logic [2:0] dly_sel = 3'd0;
    logic       ss_out_en = 1'b1;
    logic       ack_out_en = 1'b0;
    logic       ack_val = 1'b1;
    logic       hiz_force = 1'b0;
    logic       if_enable = 1'b0;
    logic       idle_level = 1'b1;
    logic       pad_o, pad_oe;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    sda_out_cond uut (
        .clk(clk), .rst_n(rst_n), .cs_tick(cs_tick), .sda_raw(sda_raw),
        .dly_sel(dly_sel), .ss_out_en(ss_out_en), .ack_out_en(ack_out_en),
        .ack_val(ack_val), .hiz_force(hiz_force), .if_enable(if_enable),
        .idle_level(idle_level), .pad_o(pad_o), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_tick();
        cs_tick = 1'b1;
        step();
        cs_tick = 1'b0;
    endtask

    // Disable, flush with idle level lv, then enable with the given select.
    task automatic restart(input logic lv, input logic [2:0] s);
        hiz_force = 1'b0; if_enable = 1'b0; idle_level = lv; dly_sel = s; cs_tick = 1'b0;
        step(); step();
        if_enable = 1'b1;
        step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(); step();
        chk("R1", "pad_o in reset", pad_o, 1'b1);
        chk("R1", "pad_oe in reset", pad_oe, 1'b0);
        rst_n = 1'b1;
        step();
        chk("R1", "pad_oe after reset", pad_oe, 1'b0);
    endtask

    task automatic t_idle();
        if_enable = 1'b0; idle_level = 1'b0; sda_raw = 1'b1;
        step();
        chk("R2", "pad_o idle low", pad_o, 1'b0);
        chk("R2", "pad_oe idle low", pad_oe, 1'b1);
        idle_level = 1'b1;
        step();
        chk("R2", "pad_o idle high", pad_o, 1'b1);
        chk("R3", "pad_oe released high", pad_oe, 1'b0);
    endtask

    task automatic t_zero_delay();
        ss_out_en = 1'b1; ack_out_en = 1'b0;
        restart(1'b1, 3'd0);
        sda_raw = 1'b0;
        #1;
        chk("R5", "same-cycle low", pad_o, 1'b0);
        chk("R3", "pull-down on low", pad_oe, 1'b1);
        sda_raw = 1'b1;
        #1;
        chk("R5", "same-cycle high", pad_o, 1'b1);
        step();
    endtask

    task automatic t_delay(input logic [2:0] s);
        ss_out_en = 1'b1; ack_out_en = 1'b0; sda_raw = 1'b0;
        restart(1'b1, s);
        chk("R9", $sformatf("flushed idle sel=%0d", s), pad_o, 1'b1);
        step(); step();
        chk("R6", $sformatf("no advance without tick sel=%0d", s), pad_o, 1'b1);
        for (int k = 1; k <= int'(s) + 1; k++) begin
            pulse_tick();
            chk("R6", $sformatf("sel=%0d after tick %0d", s, k), pad_o, (k == int'(s) + 1) ? 1'b0 : 1'b1);
        end
        sda_raw = 1'b1;
        step(); step(); step();
        chk("R6", $sformatf("hold without tick sel=%0d", s), pad_o, 1'b0);
    endtask

    task automatic t_idle_low_flush();
        ss_out_en = 1'b1; ack_out_en = 1'b0; sda_raw = 1'b1;
        restart(1'b0, 3'd3);
        chk("R9", "flushed idle low", pad_o, 1'b0);
        pulse_tick(); pulse_tick(); pulse_tick();
        chk("R9", "idle low held 3 ticks", pad_o, 1'b0);
        pulse_tick();
        chk("R6", "data after 4 ticks", pad_o, 1'b1);
    endtask

    task automatic t_ack();
        ss_out_en = 1'b0; ack_out_en = 1'b1; ack_val = 1'b0; sda_raw = 1'b1;
        restart(1'b1, 3'd0);
        chk("R7", "ack replaces data", pad_o, 1'b0);
        ss_out_en = 1'b1;
        #1;
        chk("R8", "ack blocked by start/stop", pad_o, 1'b1);
        ss_out_en = 1'b0; ack_out_en = 1'b0;
        #1;
        chk("R8", "ack disabled", pad_o, 1'b1);
        ack_out_en = 1'b1;
        restart(1'b1, 3'd2);
        pulse_tick(); pulse_tick();
        chk("R7", "delayed ack after 2 ticks", pad_o, 1'b1);
        pulse_tick();
        chk("R7", "delayed ack after 3 ticks", pad_o, 1'b0);
        ss_out_en = 1'b1; ack_out_en = 1'b0;
    endtask

    task automatic t_float();
        sda_raw = 1'b0;
        restart(1'b1, 3'd0);
        chk("R10", "run drives low", pad_oe, 1'b1);
        hiz_force = 1'b1;
        #1;
        chk("R10", "force not yet applied", pad_oe, 1'b1);
        step();
        chk("R4", "forced release oe", pad_oe, 1'b0);
        chk("R4", "forced release level", pad_o, 1'b1);
        if_enable = 1'b0; idle_level = 1'b0;
        step();
        chk("R4", "force beats idle low", pad_oe, 1'b0);
        hiz_force = 1'b0;
        step();
        chk("R10", "float to off drives idle", pad_oe, 1'b1);
        if_enable = 1'b1; sda_raw = 1'b1;
        step();
        chk("R10", "off to run follows data", pad_o, 1'b1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_idle();
        t_zero_delay();
        t_delay(3'd1);
        t_delay(3'd3);
        t_delay(3'd7);
        t_idle_low_flush();
        t_ack();
        t_float();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule